// File: doc/BRIEF.md
# Floating-Point Compare and Branch-Condition Unit

This block orders two IEEE-754 operands, either single precision (32 bits) or double precision (64 bits). It reduces the result to a 2-bit condition code and stores that code in one of a small bank of condition registers. A second, independent path reads one of those registers and decodes a 4-bit branch condition against it, producing a branch-taken flag for the fetch logic. The compare has a quiet form and a signalling form. Both forms report an invalid-operation flag to the exception logic. The quiet form raises it only for a signalling NaN, and the signalling form raises it for any NaN.

The number of condition registers is a parameter. It is 1 for the narrow machine and 4 for the wide machine. With one register, the register selectors are not used. Writes to the condition registers take effect on the clock edge. Branch evaluation is combinational from the registered code, so a branch sees a compare's result from the cycle after that compare.

Top module: `fcmp_branch_unit`

## Requirements
- R1: With `cmp_dbl_i`=0, the operands are the low 32 bits of `op_a_i` and `op_b_i`, and the upper 32 bits are ignored. The stored code is 0 when the operands are equal, 1 when a<b, and 2 when a>b. Subnormals and infinities are ordered by value.
- R2: With `cmp_dbl_i`=1, the full 64-bit operands are compared with the same 0/1/2 encoding.
- R3: When either operand is a NaN (all exponent bits set and a nonzero fraction), the stored code is 3 (unordered).
- R4: +0 and -0 compare equal. Between two negative numbers, the one with the larger magnitude is the smaller.
- R5: The code is written on the clock edge when `cmp_valid_i` is high, into register `cmp_dst_i`. It is visible on `fcc_o[2*k+1:2*k]` for register k after that edge. No register changes while `cmp_valid_i` is low, and the other registers keep their values during a write. All registers reset to 0.
- R6: For a quiet compare (`cmp_signal_i`=0), `invalid_o` is raised only when an operand is a signalling NaN, meaning the fraction MSB is 0.
- R7: For a signalling compare (`cmp_signal_i`=1), `invalid_o` is raised for any NaN operand. In both forms, `invalid_o` is high only in the cycle after an accepted compare, and it is 0 otherwise.
- R8: `br_cond_i` is decoded as follows, with the code in parentheses giving when the branch is taken:
  - 0 never
  - 1 not equal (code≠0)
  - 2 less or greater
  - 3 unordered or less
  - 4 less
  - 5 unordered or greater
  - 6 greater
  - 7 unordered
  - 8 always
  - 9 equal
  - 10 unordered or equal
  - 11 greater or equal
  - 12 not less
  - 13 less or equal
  - 14 not greater
  - 15 ordered (code≠3)
- R9: `br_taken_o` is combinational from `br_cond_i`, `br_src_i` and the registered code of register `br_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Compare request this cycle |
| cmp_dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| cmp_signal_i | input | 1 | 1 = signalling compare |
| cmp_dst_i | input | 2 | Destination condition register |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| br_cond_i | input | 4 | Branch condition code |
| br_src_i | input | 2 | Condition register tested by the branch |
| br_taken_o | output | 1 | Branch condition is true |
| invalid_o | output | 1 | Invalid-operation flag of the previous compare |
| fcc_o | output | 2*NUM_FCC | All condition registers, register k at bits 2k+1:2k |

## Verification
A wrong decision in the classifier or the ordering logic shows up on `fcc_o` exactly one edge after the compare, in the slice of the addressed register. A stray write shows up as an unexpected change in a different slice, or as a change during an idle cycle. Both are checked on every cycle against a shadow copy of all registers. An error in the condition decode or in the register read select appears on `br_taken_o` with no delay. It is checked by testing every condition against every code value held in every register.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

   typedef enum logic [1:0] {
      FCC_EQ = 2'd0,
      FCC_LT = 2'd1,
      FCC_GT = 2'd2,
      FCC_UN = 2'd3
   } fcc_e;

   typedef enum logic [3:0] {
      BC_NEVER = 4'd0,
      BC_NE    = 4'd1,
      BC_LG    = 4'd2,
      BC_UL    = 4'd3,
      BC_L     = 4'd4,
      BC_UG    = 4'd5,
      BC_G     = 4'd6,
      BC_U     = 4'd7,
      BC_ALWAYS= 4'd8,
      BC_E     = 4'd9,
      BC_UE    = 4'd10,
      BC_GE    = 4'd11,
      BC_UGE   = 4'd12,
      BC_LE    = 4'd13,
      BC_ULE   = 4'd14,
      BC_O     = 4'd15
   } bcond_e;

   // Largest register bank a machine can have; sets the selector width.
   localparam int unsigned FCC_MAX   = 4;
   localparam int unsigned FCC_SEL_W = $clog2(FCC_MAX);

endpackage

// File: rtl/fcb_classify.sv
// Splits one IEEE-754 operand of a given format into the properties
// the ordering logic needs.
module fcb_classify #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   parameter int unsigned MAG_W = 63,
   localparam int unsigned OP_W = 1 + EXP_W + MAN_W
) (
   input  logic [OP_W-1:0]  bits_i,
   output logic             sign_o,
   output logic             nan_o,
   output logic             snan_o,
   output logic             zero_o,
   output logic [MAG_W-1:0] mag_o
);
   if (MAG_W < EXP_W + MAN_W) begin : g_bad_mag
      $error("fcb_classify: MAG_W too small for the format");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("fcb_classify: fraction needs at least two bits");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max;
   logic             man_nz;

   assign exp_f   = bits_i[OP_W-2 -: EXP_W];
   assign man_f   = bits_i[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign man_nz  = |man_f;

   assign sign_o  = bits_i[OP_W-1];
   assign nan_o   = exp_max & man_nz;
   assign snan_o  = exp_max & man_nz & ~man_f[MAN_W-1];
   assign zero_o  = ~(|exp_f) & ~man_nz;
   assign mag_o   = MAG_W'({exp_f, man_f});

endmodule

// File: rtl/fcb_order.sv
// Four-way ordering of two classified operands plus invalid detection.
module fcb_order
   import fcb_pkg::*;
#(
   parameter int unsigned MAG_W = 63
) (
   input  logic             a_sign_i,
   input  logic             a_nan_i,
   input  logic             a_snan_i,
   input  logic             a_zero_i,
   input  logic [MAG_W-1:0] a_mag_i,
   input  logic             b_sign_i,
   input  logic             b_nan_i,
   input  logic             b_snan_i,
   input  logic             b_zero_i,
   input  logic [MAG_W-1:0] b_mag_i,
   input  logic             signal_i,
   output fcc_e             cc_o,
   output logic             invalid_o
);
   logic mag_gt;
   logic mag_eq;

   assign mag_gt = a_mag_i > b_mag_i;
   assign mag_eq = a_mag_i == b_mag_i;

   always_comb begin
      if (a_nan_i || b_nan_i) begin
         cc_o = FCC_UN;
      end else if (a_zero_i && b_zero_i) begin
         cc_o = FCC_EQ;
      end else if (a_sign_i != b_sign_i) begin
         cc_o = a_sign_i ? FCC_LT : FCC_GT;
      end else if (mag_eq) begin
         cc_o = FCC_EQ;
      end else begin
         // Both negative: larger magnitude is the smaller value.
         cc_o = (mag_gt ^ a_sign_i) ? FCC_GT : FCC_LT;
      end
   end

   assign invalid_o = signal_i ? (a_nan_i | b_nan_i) : (a_snan_i | b_snan_i);

endmodule

// File: rtl/fcb_cond_eval.sv
// Branch-condition decode. Conditions 8..15 are the complements of 0..7,
// so a three-bit base mask is built and bit 3 inverts the result.
module fcb_cond_eval
   import fcb_pkg::*;
(
   input  fcc_e        cc_i,
   input  logic [3:0]  cond_i,
   output logic        taken_o
);
   // mask bit k: taken when the code equals k (EQ,LT,GT,UN)
   logic [3:0] base_mask;

   always_comb begin
      unique case (cond_i[2:0])
         3'd0:    base_mask = 4'b0000; // never
         3'd1:    base_mask = 4'b1110; // not equal
         3'd2:    base_mask = 4'b0110; // less or greater
         3'd3:    base_mask = 4'b1010; // unordered or less
         3'd4:    base_mask = 4'b0010; // less
         3'd5:    base_mask = 4'b1100; // unordered or greater
         3'd6:    base_mask = 4'b0100; // greater
         default: base_mask = 4'b1000; // unordered
      endcase
   end

   assign taken_o = base_mask[cc_i] ^ cond_i[3];

endmodule

// File: rtl/fcmp_branch_unit.sv
module fcmp_branch_unit
   import fcb_pkg::*;
#(
   parameter int unsigned NUM_FCC   = 4,
   parameter int unsigned SGL_EXP_W = 8,
   parameter int unsigned SGL_MAN_W = 23,
   parameter int unsigned DBL_EXP_W = 11,
   parameter int unsigned DBL_MAN_W = 52,
   localparam int unsigned SGL_W    = 1 + SGL_EXP_W + SGL_MAN_W,
   localparam int unsigned DBL_W    = 1 + DBL_EXP_W + DBL_MAN_W,
   localparam int unsigned MAG_W    = DBL_EXP_W + DBL_MAN_W,
   localparam int unsigned FCC_W    = 2 * NUM_FCC
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cmp_valid_i,
   input  logic                 cmp_dbl_i,
   input  logic                 cmp_signal_i,
   input  logic [FCC_SEL_W-1:0] cmp_dst_i,
   input  logic [DBL_W-1:0]     op_a_i,
   input  logic [DBL_W-1:0]     op_b_i,
   input  logic [3:0]           br_cond_i,
   input  logic [FCC_SEL_W-1:0] br_src_i,
   output logic                 br_taken_o,
   output logic                 invalid_o,
   output logic [FCC_W-1:0]     fcc_o
);
   // ---------------- elaboration checks ----------------
   if (NUM_FCC != 1 && NUM_FCC != FCC_MAX) begin : g_bad_num
      $error("fcmp_branch_unit: NUM_FCC must be 1 or 4");
   end
   if (SGL_W > DBL_W || SGL_EXP_W + SGL_MAN_W > MAG_W) begin : g_bad_fmt
      $error("fcmp_branch_unit: single format must fit in double");
   end

   // ---------------- operand classification ----------------
   logic [DBL_W-1:0] ops [2];
   logic [1:0]       op_sign, op_nan, op_snan, op_zero;
   logic [MAG_W-1:0] op_mag [2];

   assign ops[0] = op_a_i;
   assign ops[1] = op_b_i;

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      logic             s_sign, s_nan, s_snan, s_zero;
      logic             d_sign, d_nan, d_snan, d_zero;
      logic [MAG_W-1:0] s_mag, d_mag;

      fcb_classify #(
         .EXP_W (SGL_EXP_W),
         .MAN_W (SGL_MAN_W),
         .MAG_W (MAG_W)
      ) u_sgl (
         .bits_i (ops[k][SGL_W-1:0]),
         .sign_o (s_sign),
         .nan_o  (s_nan),
         .snan_o (s_snan),
         .zero_o (s_zero),
         .mag_o  (s_mag)
      );

      fcb_classify #(
         .EXP_W (DBL_EXP_W),
         .MAN_W (DBL_MAN_W),
         .MAG_W (MAG_W)
      ) u_dbl (
         .bits_i (ops[k]),
         .sign_o (d_sign),
         .nan_o  (d_nan),
         .snan_o (d_snan),
         .zero_o (d_zero),
         .mag_o  (d_mag)
      );

      assign op_sign[k] = cmp_dbl_i ? d_sign : s_sign;
      assign op_nan[k]  = cmp_dbl_i ? d_nan  : s_nan;
      assign op_snan[k] = cmp_dbl_i ? d_snan : s_snan;
      assign op_zero[k] = cmp_dbl_i ? d_zero : s_zero;
      assign op_mag[k]  = cmp_dbl_i ? d_mag  : s_mag;
   end

   // ---------------- ordering ----------------
   fcc_e cmp_cc;
   logic cmp_inv;

   fcb_order #(.MAG_W(MAG_W)) u_order (
      .a_sign_i  (op_sign[0]),
      .a_nan_i   (op_nan[0]),
      .a_snan_i  (op_snan[0]),
      .a_zero_i  (op_zero[0]),
      .a_mag_i   (op_mag[0]),
      .b_sign_i  (op_sign[1]),
      .b_nan_i   (op_nan[1]),
      .b_snan_i  (op_snan[1]),
      .b_zero_i  (op_zero[1]),
      .b_mag_i   (op_mag[1]),
      .signal_i  (cmp_signal_i),
      .cc_o      (cmp_cc),
      .invalid_o (cmp_inv)
   );

   // ---------------- condition register bank ----------------
   fcc_e               fcc_q [NUM_FCC];
   logic [NUM_FCC-1:0] wr_en;
   fcc_e               sel_cc;

   if (NUM_FCC == 1) begin : g_single_bank
      assign wr_en[0] = cmp_valid_i;
      assign sel_cc   = fcc_q[0];
   end else begin : g_multi_bank
      for (genvar r = 0; r < NUM_FCC; r++) begin : g_dec
         assign wr_en[r] = cmp_valid_i && (cmp_dst_i == FCC_SEL_W'(r));
      end
      assign sel_cc = fcc_q[br_src_i];
   end

   for (genvar r = 0; r < NUM_FCC; r++) begin : g_fcc
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            fcc_q[r] <= FCC_EQ;
         end else if (wr_en[r]) begin
            fcc_q[r] <= cmp_cc;
         end
      end
      assign fcc_o[2*r +: 2] = fcc_q[r];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         invalid_o <= 1'b0;
      end else begin
         invalid_o <= cmp_valid_i & cmp_inv;
      end
   end

   // ---------------- branch decode ----------------
   fcb_cond_eval u_cond (
      .cc_i    (sel_cc),
      .cond_i  (br_cond_i),
      .taken_o (br_taken_o)
   );

   // ---------------- assertions ----------------
   assert_nan_unordered_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|op_nan) |-> (cmp_cc == FCC_UN));

   assert_zero_equal_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&op_zero) |-> (cmp_cc == FCC_EQ));

   assert_idle_hold_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_valid_i |=> $stable(fcc_o));

   assert_snan_flag_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i && (|op_snan)) |=> invalid_o);

   assert_signal_flag_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i && cmp_signal_i && (|op_nan)) |=> invalid_o);

   assert_flag_pulse_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_valid_i |=> !invalid_o);

   assert_never_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_cond_i == BC_NEVER) |-> !br_taken_o);

   assert_always_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_cond_i == BC_ALWAYS) |-> br_taken_o);

   assert_ordered_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_cond_i == BC_O) |-> (br_taken_o == (sel_cc != FCC_UN)));

endmodule

// File: tb/tb_fcmp_branch_unit.sv
module tb_fcmp_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic        cmp_dbl = 1'b0;
   logic        cmp_signal = 1'b0;
   logic [1:0]  cmp_dst = 2'd0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [3:0]  br_cond = 4'd0;
   logic [1:0]  br_src = 2'd0;
   logic        br_taken;
   logic        invalid;
   logic [7:0]  fcc;

   always #2 clk = ~clk; // 250 MHz

   fcmp_branch_unit dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .cmp_valid_i  (cmp_valid),
      .cmp_dbl_i    (cmp_dbl),
      .cmp_signal_i (cmp_signal),
      .cmp_dst_i    (cmp_dst),
      .op_a_i       (op_a),
      .op_b_i       (op_b),
      .br_cond_i    (br_cond),
      .br_src_i     (br_src),
      .br_taken_o   (br_taken),
      .invalid_o    (invalid),
      .fcc_o        (fcc)
   );

   int n_chk = 0;
   int n_err = 0;
   logic done = 1'b0;

   typedef struct {
      logic [7:0] fcc;
      logic       inv;
      string      req;
   } exp_t;

   exp_t       sb_q[$];
   logic [7:0] shadow = 8'h00;
   logic [7:0] last_fcc = 8'h00;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: one compare, expected result pushed to the scoreboard.
   task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                         input logic sig, input logic [1:0] dst, input logic [1:0] ecc,
                         input logic einv, input string req);
      exp_t it;
      @(negedge clk);
      op_a = a; op_b = b; cmp_dbl = dbl; cmp_signal = sig; cmp_dst = dst;
      cmp_valid = 1'b1;
      shadow[dst*2 +: 2] = ecc;
      it.fcc = shadow; it.inv = einv; it.req = req;
      sb_q.push_back(it);
      @(negedge clk);
      cmp_valid = 1'b0;
   endtask

   // Reference branch decode from the condition table.
   function automatic logic ref_taken(input logic [3:0] c, input logic [1:0] cc);
      logic e, l, g, u;
      e = (cc == 2'd0); l = (cc == 2'd1); g = (cc == 2'd2); u = (cc == 2'd3);
      case (c)
         4'd0:  return 1'b0;
         4'd1:  return !e;
         4'd2:  return l || g;
         4'd3:  return u || l;
         4'd4:  return l;
         4'd5:  return u || g;
         4'd6:  return g;
         4'd7:  return u;
         4'd8:  return 1'b1;
         4'd9:  return e;
         4'd10: return u || e;
         4'd11: return g || e;
         4'd12: return !l;
         4'd13: return l || e;
         4'd14: return !g;
         default: return !u;
      endcase
   endfunction

   // Monitor: compares outputs after every edge against the scoreboard.
   initial begin
      @(posedge rst_n);
      forever begin
         logic v;
         @(posedge clk);
         v = cmp_valid;
         #1;
         if (done) break;
         if (v) begin
            if (sb_q.size() == 0) begin
               chk("R5 scoreboard empty", 64'd1, 64'd0);
            end else begin
               exp_t it;
               it = sb_q.pop_front();
               chk(it.req, 64'(fcc), 64'(it.fcc));
               chk({it.req, " invalid"}, 64'(invalid), 64'(it.inv));
               last_fcc = it.fcc;
            end
         end else begin
            chk("R5 idle hold", 64'(fcc), 64'(last_fcc));
            chk("R7 idle flag", 64'(invalid), 64'd0);
         end
      end
   end

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   localparam logic [31:0] S_ONE  = 32'h3F800000, S_TWO = 32'h40000000;
   localparam logic [31:0] S_MONE = 32'hBF800000, S_MTWO = 32'hC0000000;
   localparam logic [31:0] S_PZ   = 32'h00000000, S_NZ = 32'h80000000;
   localparam logic [31:0] S_QNAN = 32'h7FC00000, S_SNAN = 32'h7F800001;
   localparam logic [31:0] S_PINF = 32'h7F800000, S_NINF = 32'hFF800000;
   localparam logic [31:0] S_DEN  = 32'h00000001;
   localparam logic [63:0] D_ONE  = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000;
   localparam logic [63:0] D_M15  = 64'hBFF8000000000000;
   localparam logic [63:0] D_QNAN = 64'h7FF8000000000000, D_SNAN = 64'h7FF0000000000001;
   localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
   localparam logic [63:0] D_PZ   = 64'h0, D_NZ = 64'h8000000000000000;

   initial begin
      repeat (3) @(negedge clk);
      chk("R5 reset fcc", 64'(fcc), 64'd0);
      chk("R7 reset invalid", 64'(invalid), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single precision, upper bits garbage to show they are ignored
      do_cmp({32'hDEADBEEF, S_ONE}, {32'h12345678, S_TWO}, 0, 0, 2'd0, 2'd1, 0, "R1 1<2");
      do_cmp({32'hFFFFFFFF, S_TWO}, {32'h0, S_ONE}, 0, 0, 2'd1, 2'd2, 0, "R1 2>1");
      do_cmp({32'hAAAAAAAA, S_ONE}, {32'h55555555, S_ONE}, 0, 0, 2'd2, 2'd0, 0, "R1 eq");
      do_cmp({32'h0, S_DEN}, {32'h0, S_PZ}, 0, 0, 2'd3, 2'd2, 0, "R1 denorm>0");
      do_cmp({32'h0, S_PINF}, {32'h0, S_NINF}, 0, 0, 2'd0, 2'd2, 0, "R1 inf");
      do_cmp({32'h0, S_MONE}, {32'h0, S_MTWO}, 0, 0, 2'd1, 2'd2, 0, "R4 -1>-2");
      do_cmp({32'h0, S_PZ}, {32'h0, S_NZ}, 0, 0, 2'd2, 2'd0, 0, "R4 +0==-0");
      do_cmp({32'h0, S_MTWO}, {32'h0, S_ONE}, 0, 0, 2'd3, 2'd1, 0, "R4 -2<1");
      do_cmp({32'h0, S_ONE}, {32'h0, S_QNAN}, 0, 0, 2'd0, 2'd3, 0, "R3 R6 qnan quiet");
      do_cmp({32'h0, S_SNAN}, {32'h0, S_ONE}, 0, 0, 2'd1, 2'd3, 1, "R6 snan quiet");
      do_cmp({32'h0, S_QNAN}, {32'h0, S_ONE}, 0, 1, 2'd2, 2'd3, 1, "R7 qnan signalling");
      do_cmp({32'h0, S_ONE}, {32'h0, S_TWO}, 0, 1, 2'd3, 2'd1, 0, "R7 ordered signalling");

      // idle cycles with NaN operands and signalling set: nothing changes
      @(negedge clk);
      op_a = D_QNAN; op_b = D_SNAN; cmp_dbl = 1; cmp_signal = 1; cmp_dst = 2'd0;
      repeat (4) @(negedge clk);

      // double precision
      do_cmp(D_ONE, D_TWO, 1, 0, 2'd0, 2'd1, 0, "R2 1<2");
      do_cmp(D_M15, D_ONE, 1, 0, 2'd1, 2'd1, 0, "R2 -1.5<1");
      do_cmp(D_TWO, D_M15, 1, 0, 2'd2, 2'd2, 0, "R2 2>-1.5");
      do_cmp(D_ONE, D_ONE, 1, 0, 2'd3, 2'd0, 0, "R2 eq");
      do_cmp(D_NZ, D_PZ, 1, 0, 2'd0, 2'd0, 0, "R4 double zeros");
      do_cmp(D_SNAN, D_ONE, 1, 0, 2'd1, 2'd3, 1, "R6 double snan");
      do_cmp(D_PINF, D_QNAN, 1, 0, 2'd2, 2'd3, 0, "R3 double qnan quiet");
      do_cmp(D_ONE, D_QNAN, 1, 1, 2'd3, 2'd3, 1, "R7 double qnan signalling");

      // load EQ, LT, GT, UN into registers 0..3 for the branch sweep
      do_cmp(D_ONE, D_ONE, 1, 0, 2'd0, 2'd0, 0, "R5 load eq");
      do_cmp(D_ONE, D_TWO, 1, 0, 2'd1, 2'd1, 0, "R5 load lt");
      do_cmp(D_TWO, D_ONE, 1, 0, 2'd2, 2'd2, 0, "R5 load gt");
      do_cmp(D_QNAN, D_ONE, 1, 0, 2'd3, 2'd3, 0, "R5 load un");
      repeat (2) @(negedge clk);

      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            br_src = 2'(s); br_cond = 4'(c);
            #1;
            chk($sformatf("R8 R9 cond=%0d src=%0d", c, s), 64'(br_taken),
                64'(ref_taken(4'(c), shadow[s*2 +: 2])));
         end
      end

      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule